// File: doc/BRIEF.md
# Descriptor Ring Pointer Bank

This block holds the control state for a small set of host descriptor rings. Each ring has a 64-bit base address, an enable flag, a log2 ring size, the number of the completion queue it reports to, and two free-running 16-bit pointers. The host advances the producer (head) pointer as it posts descriptors. The hardware advances the consumer (tail) pointer as it takes them. The host reaches all of this through a plain 32-bit register port. Each ring owns a 32-byte window, and ring k starts at byte k*0x20.

A datapath on the consumer side selects a ring and sees three things at once, without waiting a cycle: whether that ring holds work, the byte address of the descriptor at the tail, and the linked completion-queue number. A one-cycle take strobe moves the tail forward by one entry. Pointers are never wrapped to the ring size when they are stored. They are masked by the ring size only when the descriptor address is formed.

To reconfigure a ring, the host first writes the control word with the enable bit clear. It then programs the base, the completion-queue number and the pointers. Last, it writes the log size with the enable bit set.

Top module: `dq_ptr_bank`

## Requirements
- R1: After reset every ring is disabled, and every register word of every ring reads as zero.
- R2: Word 0x00 of a ring window holds base address bits 31:0 and word 0x04 holds bits 63:32. Both read back as written, and ring k is addressed at k*0x20 plus the word offset.
- R3: Word 0x08 holds the log2 ring size in bits 3:0 and the enable flag in bit 31. Bits 30:4 are ignored on write and read as zero.
- R4: Word 0x0C holds a 16-bit completion-queue number. Write bits 31:16 are dropped and read as zero. The number of the selected ring also appears on `cons_cq_idx`.
- R5: Word 0x10 is the head pointer. Its low 16 bits are taken from a write at any time, whether the ring is enabled or not.
- R6: Word 0x18 is the tail pointer. A host write to it takes effect only while the ring is disabled, and is ignored while the ring is enabled.
- R7: Words 0x14 and 0x1C read as zero. Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next read.
- R8: `cons_has_work` is high exactly when the selected ring is enabled and its head differs from its tail.
- R9: `cons_desc_addr` equals base + 16 * (tail AND (2^log_size - 1)), computed modulo 2^64.
- R10: A take strobe on a ring that has work adds one to its tail at the next clock edge. A take on a ring without work leaves the tail unchanged.
- R11: Head and tail are free-running 16-bit counters, so the tail steps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Host write strobe |
| reg_rd_en | input | 1 | Host read strobe |
| reg_addr | input | ADDR_W (7) | Byte address: ring number above bit 4, word in bits 4:2 |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, registered |
| cons_qsel | input | QSEL_W (2) | Ring selected by the consumer |
| cons_take | input | 1 | Consume one descriptor from the selected ring |
| cons_has_work | output | 1 | Selected ring is enabled and not empty |
| cons_desc_addr | output | 64 | Byte address of the selected ring's tail descriptor |
| cons_cq_idx | output | 16 | Completion-queue number of the selected ring |

## Verification
Read data is due one edge after the read strobe. The bench raises the strobe on a falling edge and compares `reg_rdata` at the next falling edge. The consumer outputs are combinational from the ring select and the stored state, so they are checked 1 ns after the select changes, with no clock edge in between. A take or a register write changes state at the rising edge that samples it, so every result of it is checked from the following falling edge onward, through a register read or through the consumer outputs.

// File: rtl/dqp_pkg.sv
package dqp_pkg;
    localparam int PTR_W     = 16;
    localparam int LOG_W     = 4;
    localparam int CQ_W      = 16;
    localparam int BASE_W    = 64;
    localparam int DESC_LOG2 = 4;
    localparam int WIN_LOG2  = 5;

    typedef enum logic [2:0] {
        W_BASE_LO = 3'd0,
        W_BASE_HI = 3'd1,
        W_CTRL    = 3'd2,
        W_CQ      = 3'd3,
        W_HEAD    = 3'd4,
        W_GAP0    = 3'd5,
        W_TAIL    = 3'd6,
        W_GAP1    = 3'd7
    } word_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              active;
        logic [LOG_W-1:0]  log_size;
        logic [CQ_W-1:0]   cq_idx;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
    } qstate_t;
endpackage

// File: rtl/dqp_queue.sv
module dqp_queue
    import dqp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  word_e       wr_word,
    input  logic [31:0] wr_data,
    input  logic        take,
    output qstate_t     state
);
    qstate_t st_d, st_q;
    logic    can_take;

    assign can_take = take && st_q.active && (st_q.head != st_q.tail);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_word)
                W_BASE_LO: st_d.base[31:0]      = wr_data;
                W_BASE_HI: st_d.base[63:32]     = wr_data;
                W_CTRL: begin
                    st_d.active   = wr_data[31];
                    st_d.log_size = wr_data[LOG_W-1:0];
                end
                W_CQ:      st_d.cq_idx = wr_data[CQ_W-1:0];
                W_HEAD:    st_d.head   = wr_data[PTR_W-1:0];
                W_TAIL: begin
                    if (!st_q.active)
                        st_d.tail = wr_data[PTR_W-1:0];
                end
                default: ;
            endcase
        end
        if (can_take)
            st_d.tail = st_q.tail + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign state = st_q;

    // R6: while enabled, only a take can move the tail
    a_r6_tail_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !take) |=> $stable(st_q.tail));

    // R10: a take on a ring with work moves the tail by exactly one
    a_r10_take_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q.active && st_q.head != st_q.tail) |=> (st_q.tail == $past(st_q.tail) + 16'd1));

    // R5: the head changes only by a host write
    a_r5_head_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_word == W_HEAD) |=> $stable(st_q.head));

    // R11: the tail wraps from all ones to zero
    a_r11_tail_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q.active && st_q.head != st_q.tail && st_q.tail == 16'hFFFF) |=> (st_q.tail == 16'h0000));
endmodule

// File: rtl/dqp_read_mux.sv
module dqp_read_mux
    import dqp_pkg::*;
(
    input  qstate_t     st,
    input  word_e       word,
    output logic [31:0] data
);
    always_comb begin
        case (word)
            W_BASE_LO: data = st.base[31:0];
            W_BASE_HI: data = st.base[63:32];
            W_CTRL:    data = {st.active, {(31-LOG_W){1'b0}}, st.log_size};
            W_CQ:      data = {{(32-CQ_W){1'b0}}, st.cq_idx};
            W_HEAD:    data = {{(32-PTR_W){1'b0}}, st.head};
            W_TAIL:    data = {{(32-PTR_W){1'b0}}, st.tail};
            default:   data = 32'd0;
        endcase
    end
endmodule

// File: rtl/dqp_slot_addr.sv
module dqp_slot_addr
    import dqp_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [LOG_W-1:0]  log_size,
    input  logic [PTR_W-1:0]  ptr,
    output logic [BASE_W-1:0] addr
);
    localparam int PAD_W = BASE_W - PTR_W - DESC_LOG2;

    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] slot;

    always_comb begin
        mask = (PTR_W'(1) << log_size) - PTR_W'(1);
        slot = ptr & mask;
        addr = base + {{PAD_W{1'b0}}, slot, {DESC_LOG2{1'b0}}};
    end
endmodule

// File: rtl/dq_ptr_bank.sv
module dq_ptr_bank
    import dqp_pkg::*;
#(
    parameter  int NUM_QUEUES = 4,
    localparam int QSEL_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
    localparam int ADDR_W     = QSEL_W + WIN_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [QSEL_W-1:0] cons_qsel,
    input  logic              cons_take,
    output logic              cons_has_work,
    output logic [63:0]       cons_desc_addr,
    output logic [15:0]       cons_cq_idx
);
    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    rd_t               rd_d, rd_q;
    qstate_t           q_state [NUM_QUEUES];
    qstate_t           sel_st;
    qstate_t           rd_st;
    logic              rd_hit;
    logic [31:0]       rd_word_data;
    logic [QSEL_W-1:0] acc_q;
    word_e             acc_word;

    assign acc_q    = reg_addr[ADDR_W-1:WIN_LOG2];
    assign acc_word = word_e'(reg_addr[WIN_LOG2-1:2]);

    for (genvar k = 0; k < NUM_QUEUES; k++) begin : g_ring
        dqp_queue u_ring (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr_en && (int'(acc_q) == k)),
            .wr_word (acc_word),
            .wr_data (reg_wdata),
            .take    (cons_take && (int'(cons_qsel) == k)),
            .state   (q_state[k])
        );
    end

    always_comb begin
        sel_st = '0;
        if (int'(cons_qsel) < NUM_QUEUES)
            sel_st = q_state[cons_qsel];
        rd_hit = int'(acc_q) < NUM_QUEUES;
        rd_st  = '0;
        if (rd_hit)
            rd_st = q_state[acc_q];
    end

    dqp_read_mux u_rmux (
        .st   (rd_st),
        .word (acc_word),
        .data (rd_word_data)
    );

    dqp_slot_addr u_addr (
        .base     (sel_st.base),
        .log_size (sel_st.log_size),
        .ptr      (sel_st.tail),
        .addr     (cons_desc_addr)
    );

    always_comb begin
        rd_d = rd_q;
        if (reg_rd_en)
            rd_d.rdata = rd_hit ? rd_word_data : 32'd0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign reg_rdata     = rd_q.rdata;
    assign cons_has_work = sel_st.active && (sel_st.head != sel_st.tail);
    assign cons_cq_idx   = sel_st.cq_idx;

    // R7: unused words in a window read back as zero one cycle later
    a_r7_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && (reg_addr[4:2] == 3'd5 || reg_addr[4:2] == 3'd7)) |=> (reg_rdata == 32'd0));
endmodule

// File: tb/test_dq_ptr_bank.sv
module test_dq_ptr_bank;
    localparam int NQ     = 4;
    localparam int QSEL_W = 2;
    localparam int ADDR_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic              reg_rd_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [QSEL_W-1:0] cons_qsel = '0;
    logic              cons_take = 1'b0;
    logic              cons_has_work;
    logic [63:0]       cons_desc_addr;
    logic [15:0]       cons_cq_idx;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dq_ptr_bank #(.NUM_QUEUES(NQ)) i_dq_ptr_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cons_qsel(cons_qsel), .cons_take(cons_take), .cons_has_work(cons_has_work),
        .cons_desc_addr(cons_desc_addr), .cons_cq_idx(cons_cq_idx)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int q, input int off, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = ADDR_W'(q * 32 + off);
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int q, input int off, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd_en = 1'b1;
        reg_addr  = ADDR_W'(q * 32 + off);
        @(negedge clk);
        reg_rd_en = 1'b0;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic take(input int q);
        @(negedge clk);
        cons_qsel = QSEL_W'(q);
        cons_take = 1'b1;
        @(negedge clk);
        cons_take = 1'b0;
    endtask

    task automatic cons_chk(input int q, input logic work, input logic [63:0] addr, input string tag);
        @(negedge clk);
        cons_qsel = QSEL_W'(q);
        #1;
        chk({tag, " work"}, 64'(cons_has_work), 64'(work));
        chk({tag, " addr"}, cons_desc_addr, addr);
    endtask

    function automatic logic [63:0] exp_addr(input logic [63:0] b, input int lg, input logic [15:0] t);
        logic [15:0] m;
        m = 16'((32'd1 << lg) - 1);
        return b + (64'(t & m) << 4);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] base;
        logic [15:0] t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every word of every ring reads zero, no work
        for (int q = 0; q < NQ; q++) begin
            for (int w = 0; w < 8; w++) rd(q, w * 4, 32'd0, "R1 reset word");
            cons_chk(q, 1'b0, 64'd0, "R1 reset consumer");
        end

        // R2 R4 R5: per-ring fields and window placement
        for (int q = 0; q < NQ; q++) begin
            wr(q, 'h00, 32'h1000_0000 + 32'(q * 'h111));
            wr(q, 'h04, 32'h0000_00A0 + 32'(q));
            wr(q, 'h0C, 32'hFFFF_0100 + 32'(q));
            wr(q, 'h10, 32'h1234_0000 | 32'(q * 7));
        end
        for (int q = 0; q < NQ; q++) begin
            rd(q, 'h00, 32'h1000_0000 + 32'(q * 'h111), "R2 base lo");
            rd(q, 'h04, 32'h0000_00A0 + 32'(q), "R2 base hi");
            rd(q, 'h0C, 32'h0000_0100 + 32'(q), "R4 cq index");
            rd(q, 'h10, 32'(q * 7), "R5 head");
            @(negedge clk);
            cons_qsel = QSEL_W'(q);
            #1;
            chk("R4 cq on consumer port", 64'(cons_cq_idx), 64'(16'h0100 + 16'(q)));
        end

        // R3: control word field packing
        wr(3, 'h08, 32'h7FFF_FFF5);
        rd(3, 'h08, 32'h0000_0005, "R3 ctrl reserved bits");
        wr(3, 'h08, 32'hFFFF_FFFF);
        rd(3, 'h08, 32'h8000_000F, "R3 ctrl all ones");
        wr(3, 'h08, 32'h0000_0000);
        rd(3, 'h08, 32'h0000_0000, "R3 ctrl cleared");

        // R9 R8: address sweep over every log size
        base = 64'h0000_0001_2345_6000;
        wr(2, 'h00, base[31:0]);
        wr(2, 'h04, base[63:32]);
        for (int lg = 0; lg < 16; lg++) begin
            t = 16'hA5C3 + 16'(lg * 'h0101);
            wr(2, 'h08, 32'(lg));
            wr(2, 'h18, 32'(t));
            wr(2, 'h10, 32'(t + 16'd1));
            wr(2, 'h08, 32'h8000_0000 | 32'(lg));
            cons_chk(2, 1'b1, exp_addr(base, lg, t), "R9 addr sweep");
        end
        // R9: 64-bit wrap of base plus offset
        base = 64'hFFFF_FFFF_FFFF_FFF0;
        wr(2, 'h08, 32'd4);
        wr(2, 'h00, base[31:0]);
        wr(2, 'h04, base[63:32]);
        wr(2, 'h18, 32'd3);
        wr(2, 'h10, 32'd9);
        wr(2, 'h08, 32'h8000_0004);
        cons_chk(2, 1'b1, 64'h20, "R9 base wrap");

        // R6: tail write ignored while enabled
        wr(2, 'h18, 32'd7);
        rd(2, 'h18, 32'd3, "R6 tail locked while active");
        wr(2, 'h10, 32'd200);
        rd(2, 'h10, 32'd200, "R5 head write while active");
        wr(2, 'h08, 32'd4);
        wr(2, 'h18, 32'd7);
        rd(2, 'h18, 32'd7, "R6 tail write while inactive");

        // R10 R11: consume across the 16-bit wrap
        base = 64'h0000_0000_0004_0000;
        wr(1, 'h08, 32'd0);
        wr(1, 'h00, base[31:0]);
        wr(1, 'h04, base[63:32]);
        wr(1, 'h18, 32'h0000_FFFE);
        wr(1, 'h10, 32'h0000_0001);
        wr(1, 'h08, 32'h8000_0003);
        cons_chk(1, 1'b1, exp_addr(base, 3, 16'hFFFE), "R8 has work before take");
        take(1);
        rd(1, 'h18, 32'h0000_FFFF, "R10 first take");
        take(1);
        rd(1, 'h18, 32'h0000_0000, "R11 tail wraps to zero");
        cons_chk(1, 1'b1, exp_addr(base, 3, 16'h0000), "R11 addr after wrap");
        take(1);
        rd(1, 'h18, 32'h0000_0001, "R10 third take");
        cons_chk(1, 1'b0, exp_addr(base, 3, 16'h0001), "R8 empty after catch-up");
        take(1);
        rd(1, 'h18, 32'h0000_0001, "R10 take on empty ignored");

        // R8 R10: disabled ring with pending entries
        wr(0, 'h08, 32'd2);
        wr(0, 'h10, 32'd5);
        cons_chk(0, 1'b0, exp_addr(64'h0000_00A0_1000_0000, 2, 16'd0), "R8 inactive no work");
        take(0);
        rd(0, 'h18, 32'd0, "R10 take on inactive ignored");

        // R7: gap words
        for (int q = 0; q < NQ; q++) begin
            rd(q, 'h14, 32'd0, "R7 gap 0x14");
            rd(q, 'h1C, 32'd0, "R7 gap 0x1C");
        end
        // R7: read data holds between reads
        rd(1, 'h10, 32'd1, "R7 head read");
        repeat (3) @(negedge clk);
        chk("R7 rdata holds", 64'(reg_rdata), 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule